// File: doc/BRIEF.md
# Multi-Processor Interrupt Hub

This block collects device interrupts for a small shared-memory multiprocessor. It routes them to each processor, together with inter-processor and interval-timer interrupts. A single raw vector holds one bit per device interrupt source. Other logic sets or clears one bit per cycle by giving the source number.

Every processor has its own enable mask over that shared vector. The AND of the raw vector with a mask is that processor's pending set, and the processor's device interrupt line is high while any pending bit is set.

Next to the device path, each processor has one inter-processor interrupt flag and one timer flag. Both are set from bit vectors of target processors. A timer tick sets the timer flag of every processor. Software reaches the masks and the status vectors through a single-cycle register port: write strobe, address and write data, with read data combinational from the address.

Top module: `irq_hub`

## Requirements
- R1: After reset, every interrupt output is 0 and every register (masks, pending, raw vector, inter-processor flags, timer flags) reads 0.
- R2: When `post_valid` is high at a clock edge, raw bit `post_num` is 1 after that edge. The raw vector reads at address 8 (kind 2, processor bits ignored), with source n in data bit n.
- R3: When `clr_valid` is high at a clock edge, raw bit `clr_num` is 0 after that edge. If a post and a clear name the same source in the same cycle, the bit ends up 1.
- R4: The address is {kind[2:0], cpu[1:0]}. Kind 0 is processor `cpu`'s 64-bit mask, read/write. A write to one processor's mask changes no other mask.
- R5: Kind 1 reads processor `cpu`'s pending vector, equal to raw AND that processor's mask. Writes to kind 1 leave every register and output unchanged.
- R6: `dev_irq[c]` is 1 exactly when processor c's pending vector is non-zero. It follows the raw vector and the mask in the cycle after the edge that updated them.
- R7: `ipi_req` sets the inter-processor flag of each selected processor, bit c for processor c. The flags drive `ipi_irq` directly, and unselected flags keep their value.
- R8: Both the `ipi_clr` input and a write to kind 3 clear the inter-processor flags whose bits are 1 (write data bits [3:0], write-one-to-clear), and only those. A request and a clear of the same flag in one cycle leave it set. Kind 3 reads the flags in bits [3:0].
- R9: `rtc_tick` sets the timer flag of every processor. The flags drive `tmr_irq` directly.
- R10: Both `tmr_clr` and a write to kind 4 clear only the selected timer flags (write-one-to-clear). A tick in the same cycle as a clear leaves every flag set. Kind 4 reads the flags in bits [3:0].
- R11: Kinds 5 to 7 read as 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Set the raw bit named by post_num |
| post_num | input | 6 | Source number to set |
| clr_valid | input | 1 | Clear the raw bit named by clr_num |
| clr_num | input | 6 | Source number to clear |
| ipi_req | input | 4 | Processors to receive an inter-processor interrupt |
| ipi_clr | input | 4 | Processors whose inter-processor flag is cleared |
| rtc_tick | input | 1 | Timer event for all processors |
| tmr_clr | input | 4 | Processors whose timer flag is cleared |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {kind, cpu} |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| dev_irq | output | 4 | Per-processor device interrupt |
| ipi_irq | output | 4 | Per-processor inter-processor interrupt |
| tmr_irq | output | 4 | Per-processor timer interrupt |

## Verification
A wrong raw bit or mask appears on `dev_irq` and in the pending read one cycle after the edge that stored it. This holds only when the bench has set a matching mask bit, so the tests pair each post with masks chosen to expose it on one processor and hide it on another. A stale or lost flag shows on `ipi_irq` or `tmr_irq` one cycle after the set or clear. Same-cycle set/clear collisions are driven on purpose so that a reversed priority appears at once.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   typedef enum logic [2:0] {
      KIND_MASK = 3'd0,
      KIND_PEND = 3'd1,
      KIND_RAW  = 3'd2,
      KIND_IPI  = 3'd3,
      KIND_TMR  = 3'd4
   } reg_kind_e;

   localparam int KIND_W = 3;
endpackage

// File: rtl/irq_raw_vec.sv
module irq_raw_vec #(
   parameter int NUM_SRC = 64,
   parameter int SRC_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               post_valid,
   input  logic [SRC_W-1:0]   post_num,
   input  logic               clr_valid,
   input  logic [SRC_W-1:0]   clr_num,
   output logic [NUM_SRC-1:0] raw_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic set_hit, clr_hit;
      assign set_hit = post_valid && (post_num == SRC_W'(i));
      assign clr_hit = clr_valid && (clr_num == SRC_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n)       raw_q[i] <= 1'b0;
         else if (set_hit) raw_q[i] <= 1'b1;
         else if (clr_hit) raw_q[i] <= 1'b0;
      end
   end

   assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid && (int'(post_num) < NUM_SRC) |=> raw_q[$past(post_num)]);

   assert_clear_unless_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid && (int'(clr_num) < NUM_SRC) && !(post_valid && post_num == clr_num)
      |=> !raw_q[$past(clr_num)]);
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 64,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] raw,
   input  logic               mask_we,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] pend,
   output logic               dev_irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= wdata[NUM_SRC-1:0];
   end

   assign pend = raw & mask_q;

   if (REG_OUT) begin : g_reg_out
      logic dev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) dev_q <= 1'b0;
         else        dev_q <= |pend;
      end
      assign dev_irq = dev_q;
   end else begin : g_comb_out
      assign dev_irq = |pend;
   end

   assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> mask_q == $past(wdata[NUM_SRC-1:0]));

   assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CPU-1:0] set_vec,
   input  logic [NUM_CPU-1:0] clr_vec,
   output logic [NUM_CPU-1:0] flags
);
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)          flags[c] <= 1'b0;
         else if (set_vec[c]) flags[c] <= 1'b1;
         else if (clr_vec[c]) flags[c] <= 1'b0;
      end

      // R7 / R9: a set always lands
      assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[c] |=> flags[c]);
      // R8 / R10: clear acts only without a set
      assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         clr_vec[c] && !set_vec[c] |=> !flags[c]);
      assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !set_vec[c] && !clr_vec[c] |=> $stable(flags[c]));
   end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_hub_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 64,
   parameter int CPU_W   = 2,
   parameter int ADDR_W  = 5
) (
   input  logic                            reg_wr,
   input  logic [ADDR_W-1:0]               reg_addr,
   input  logic [DATA_W-1:0]               reg_wdata,
   input  logic [NUM_CPU-1:0][NUM_SRC-1:0] masks,
   input  logic [NUM_CPU-1:0][NUM_SRC-1:0] pends,
   input  logic [NUM_SRC-1:0]              raw,
   input  logic [NUM_CPU-1:0]              ipi_flags,
   input  logic [NUM_CPU-1:0]              tmr_flags,
   output logic [NUM_CPU-1:0]              mask_we,
   output logic [NUM_CPU-1:0]              ipi_w1c,
   output logic [NUM_CPU-1:0]              tmr_w1c,
   output logic [DATA_W-1:0]               reg_rdata
);
   logic [KIND_W-1:0] kind;
   logic [CPU_W-1:0]  cpu_idx;
   logic              cpu_ok;

   assign kind    = reg_addr[ADDR_W-1:CPU_W];
   assign cpu_idx = reg_addr[CPU_W-1:0];
   assign cpu_ok  = int'(cpu_idx) < NUM_CPU;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
      assign mask_we[c] = reg_wr && (kind == KIND_MASK) && (cpu_idx == CPU_W'(c));
   end

   assign ipi_w1c = (reg_wr && kind == KIND_IPI) ? reg_wdata[NUM_CPU-1:0] : '0;
   assign tmr_w1c = (reg_wr && kind == KIND_TMR) ? reg_wdata[NUM_CPU-1:0] : '0;

   always_comb begin
      reg_rdata = '0;
      case (kind)
         KIND_MASK: if (cpu_ok) reg_rdata[NUM_SRC-1:0] = masks[cpu_idx];
         KIND_PEND: if (cpu_ok) reg_rdata[NUM_SRC-1:0] = pends[cpu_idx];
         KIND_RAW:  reg_rdata[NUM_SRC-1:0] = raw;
         KIND_IPI:  reg_rdata[NUM_CPU-1:0] = ipi_flags;
         KIND_TMR:  reg_rdata[NUM_CPU-1:0] = tmr_flags;
         default:   reg_rdata = '0;
      endcase
   end

   always_comb begin
      if (kind > KIND_TMR)
         assert_unmapped_silent_R11: assert (mask_we == '0 && ipi_w1c == '0 && tmr_w1c == '0);
   end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int  NUM_CPU     = 4,
   parameter int  NUM_SRC     = 64,
   parameter int  DATA_W      = 64,
   parameter bit  REG_DEV_OUT = 1'b0,
   localparam int SRC_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int ADDR_W      = CPU_W + KIND_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               post_valid,
   input  logic [SRC_W-1:0]   post_num,
   input  logic               clr_valid,
   input  logic [SRC_W-1:0]   clr_num,
   input  logic [NUM_CPU-1:0] ipi_req,
   input  logic [NUM_CPU-1:0] ipi_clr,
   input  logic               rtc_tick,
   input  logic [NUM_CPU-1:0] tmr_clr,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_CPU-1:0] dev_irq,
   output logic [NUM_CPU-1:0] ipi_irq,
   output logic [NUM_CPU-1:0] tmr_irq
);
   if (NUM_CPU < 1 || NUM_CPU > DATA_W) begin : g_bad_cpu
      $error("irq_hub: NUM_CPU must lie in 1..DATA_W");
   end
   if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_hub: NUM_SRC must lie in 2..DATA_W");
   end

   logic [NUM_SRC-1:0]              raw;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] masks;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] pends;
   logic [NUM_CPU-1:0]              mask_we, ipi_w1c, tmr_w1c;

   irq_raw_vec #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_raw (
      .clk(clk), .rst_n(rst_n),
      .post_valid(post_valid), .post_num(post_num),
      .clr_valid(clr_valid), .clr_num(clr_num),
      .raw_q(raw)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      irq_cpu_slice #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .REG_OUT(REG_DEV_OUT)) u_slice (
         .clk(clk), .rst_n(rst_n), .raw(raw),
         .mask_we(mask_we[c]), .wdata(reg_wdata),
         .mask_q(masks[c]), .pend(pends[c]), .dev_irq(dev_irq[c])
      );
   end

   irq_flag_bank #(.NUM_CPU(NUM_CPU)) u_ipi (
      .clk(clk), .rst_n(rst_n),
      .set_vec(ipi_req), .clr_vec(ipi_clr | ipi_w1c),
      .flags(ipi_irq)
   );

   irq_flag_bank #(.NUM_CPU(NUM_CPU)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .set_vec({NUM_CPU{rtc_tick}}), .clr_vec(tmr_clr | tmr_w1c),
      .flags(tmr_irq)
   );

   irq_reg_port #(
      .NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W),
      .CPU_W(CPU_W), .ADDR_W(ADDR_W)
   ) u_port (
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .masks(masks), .pends(pends), .raw(raw),
      .ipi_flags(ipi_irq), .tmr_flags(tmr_irq),
      .mask_we(mask_we), .ipi_w1c(ipi_w1c), .tmr_w1c(tmr_w1c),
      .reg_rdata(reg_rdata)
   );

   assert_tick_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rtc_tick |=> &tmr_irq);

   assert_ipi_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ipi_irq & $past(ipi_req)) == $past(ipi_req));

   assert_after_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (ipi_irq == '0 && tmr_irq == '0));
endmodule

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        post_valid, clr_valid, rtc_tick, reg_wr;
   logic [5:0]  post_num, clr_num;
   logic [3:0]  ipi_req, ipi_clr, tmr_clr;
   logic [4:0]  reg_addr;
   logic [63:0] reg_wdata, reg_rdata;
   logic [3:0]  dev_irq, ipi_irq, tmr_irq;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   irq_hub dut (
      .clk(clk), .rst_n(rst_n),
      .post_valid(post_valid), .post_num(post_num),
      .clr_valid(clr_valid), .clr_num(clr_num),
      .ipi_req(ipi_req), .ipi_clr(ipi_clr),
      .rtc_tick(rtc_tick), .tmr_clr(tmr_clr),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
   );

   function automatic logic [4:0] ad(input int kind, input int cpu);
      return 5'(kind * 4 + cpu);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [63:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [4:0] a, input logic [63:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic post(input int n);
      post_valid = 1'b1; post_num = 6'(n);
      @(negedge clk);
      post_valid = 1'b0;
   endtask

   task automatic clear(input int n);
      clr_valid = 1'b1; clr_num = 6'(n);
      @(negedge clk);
      clr_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [63:0] d;
      chk("R1 dev_irq", 64'(dev_irq), 0);
      chk("R1 ipi_irq", 64'(ipi_irq), 0);
      chk("R1 tmr_irq", 64'(tmr_irq), 0);
      for (int c = 0; c < 4; c++) begin
         rd(ad(0, c), d); chk("R1 mask", d, 0);
         rd(ad(1, c), d); chk("R1 pend", d, 0);
      end
      rd(ad(2, 0), d); chk("R1 raw", d, 0);
      rd(ad(3, 0), d); chk("R1 ipi reg", d, 0);
      rd(ad(4, 0), d); chk("R1 tmr reg", d, 0);
   endtask

   task automatic t_post_clear;
      logic [63:0] d;
      post(5);
      rd(ad(2, 0), d); chk("R2 post 5", d, 64'h20);
      post(63);
      rd(ad(2, 1), d); chk("R2 post 63", d, 64'h8000_0000_0000_0020);
      clear(5);
      rd(ad(2, 0), d); chk("R3 clear 5", d, 64'h8000_0000_0000_0000);
      post_valid = 1'b1; post_num = 6'd10; clr_valid = 1'b1; clr_num = 6'd10;
      @(negedge clk);
      post_valid = 1'b0; clr_valid = 1'b0;
      rd(ad(2, 0), d); chk("R3 post wins", d, 64'h8000_0000_0000_0400);
      post_valid = 1'b1; post_num = 6'd1; clr_valid = 1'b1; clr_num = 6'd63;
      @(negedge clk);
      post_valid = 1'b0; clr_valid = 1'b0;
      rd(ad(2, 0), d); chk("R3 distinct post+clear", d, 64'h402);
      clear(10); clear(1);
      rd(ad(2, 0), d); chk("R3 all cleared", d, 0);
      chk("R6 no mask no irq", 64'(dev_irq), 0);
   endtask

   task automatic t_mask;
      logic [63:0] d;
      wr(ad(0, 0), 64'hF0);
      wr(ad(0, 1), 64'h0F);
      rd(ad(0, 0), d); chk("R4 mask0", d, 64'hF0);
      rd(ad(0, 1), d); chk("R4 mask1", d, 64'h0F);
      rd(ad(0, 2), d); chk("R4 mask2 untouched", d, 0);
      post(4);
      chk("R6 dev_irq cpu0 only", 64'(dev_irq), 64'b0001);
      rd(ad(1, 0), d); chk("R5 pend0", d, 64'h10);
      rd(ad(1, 1), d); chk("R5 pend1", d, 0);
      wr(ad(1, 0), 64'hFF);
      rd(ad(1, 0), d); chk("R5 pend read-only", d, 64'h10);
      rd(ad(0, 0), d); chk("R5 mask after pend write", d, 64'hF0);
      post(0);
      chk("R6 dev_irq cpu0+1", 64'(dev_irq), 64'b0011);
      clear(4);
      chk("R6 dev_irq cpu1", 64'(dev_irq), 64'b0010);
      wr(ad(0, 1), 64'h0);
      chk("R6 mask drop", 64'(dev_irq), 64'b0000);
      clear(0);
   endtask

   task automatic t_ipi;
      logic [63:0] d;
      ipi_req = 4'b0101; @(negedge clk); ipi_req = '0;
      chk("R7 ipi set", 64'(ipi_irq), 64'b0101);
      ipi_req = 4'b0010; @(negedge clk); ipi_req = '0;
      chk("R7 ipi accumulate", 64'(ipi_irq), 64'b0111);
      ipi_clr = 4'b0001; @(negedge clk); ipi_clr = '0;
      chk("R8 ipi clr input", 64'(ipi_irq), 64'b0110);
      wr(ad(3, 0), 64'b0100);
      chk("R8 ipi w1c", 64'(ipi_irq), 64'b0010);
      rd(ad(3, 0), d); chk("R8 ipi read", d, 64'b0010);
      ipi_req = 4'b1000; ipi_clr = 4'b1010; @(negedge clk);
      ipi_req = '0; ipi_clr = '0;
      chk("R8 set wins", 64'(ipi_irq), 64'b1000);
      wr(ad(3, 0), 64'hF);
      chk("R8 ipi w1c all", 64'(ipi_irq), 0);
   endtask

   task automatic t_tmr;
      logic [63:0] d;
      rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
      chk("R9 tick all", 64'(tmr_irq), 64'b1111);
      tmr_clr = 4'b0011; @(negedge clk); tmr_clr = '0;
      chk("R10 tmr clr input", 64'(tmr_irq), 64'b1100);
      wr(ad(4, 0), 64'b1000);
      rd(ad(4, 0), d); chk("R10 tmr w1c", d, 64'b0100);
      rtc_tick = 1'b1; tmr_clr = 4'b1111; @(negedge clk);
      rtc_tick = 1'b0; tmr_clr = '0;
      chk("R10 tick wins", 64'(tmr_irq), 64'b1111);
      wr(ad(4, 0), 64'hF);
      chk("R10 w1c all", 64'(tmr_irq), 0);
   endtask

   task automatic t_unmapped;
      logic [63:0] d;
      ipi_req = 4'b0011; rtc_tick = 1'b1; @(negedge clk);
      ipi_req = '0; rtc_tick = 1'b0;
      for (int k = 5; k < 8; k++) begin
         wr(ad(k, 0), '1);
         rd(ad(k, 0), d); chk("R11 unmapped read", d, 0);
      end
      chk("R11 ipi kept", 64'(ipi_irq), 64'b0011);
      chk("R11 tmr kept", 64'(tmr_irq), 64'b1111);
      rd(ad(0, 0), d); chk("R11 mask kept", d, 64'hF0);
   endtask

   initial begin
      rst_n = 1'b0; post_valid = 0; clr_valid = 0; rtc_tick = 0; reg_wr = 0;
      post_num = 0; clr_num = 0; ipi_req = 0; ipi_clr = 0; tmr_clr = 0;
      reg_addr = 0; reg_wdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_post_clear();
      t_mask();
      t_ipi();
      t_tmr();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule